// File: doc/BRIEF.md
# Pin External Interrupt Controller

This block turns up to 32 pin inputs into interrupt events for a parent interrupt controller. Each line carries a 4-bit trigger field that selects one of five conditions: a rising edge, a falling edge, either edge, a high level or a low level. It also has an enable bit and a sticky pending bit. Pin inputs are brought into the clock domain by a two-stage synchronizer. Edges are found by comparing the newest synchronized sample with the one before it.

A line can raise an event only while the pin multiplexer reports that its pin is routed to the interrupt function. Software reads the pending word and clears bits by writing ones, so writing back a value just read acknowledges every event in it. The single interrupt output is a registered OR over all lines of pending AND enable.

Register access uses a plain 32-bit bus with a select, a write strobe, a byte address and read data that follows the address in the same cycle.

Top module: `pin_eint_ctrl`

## Requirements
- R1: After reset every trigger field, every enable bit and every pending bit reads as zero, and `irq_out` is low.
- R2: Trigger fields sit in four words at byte offsets 0x200, 0x204, 0x208 and 0x20C. Line n uses bits [4*(n mod 8)+3 : 4*(n mod 8)] of the word at 0x200 + 4*(n/8). Every written field reads back unchanged.
- R3: Code 0 (rising edge) sets the pending bit once per low-to-high transition. A pin that stays high, or that falls, sets nothing further.
- R4: Code 1 (falling edge) sets the pending bit on a high-to-low transition and not on a low-to-high one.
- R5: Code 4 (both edges) sets the pending bit on either transition.
- R6: Code 2 (high level) and code 3 (low level) set the pending bit on every cycle the level holds. A clear written while the level is still active leaves the bit set.
- R7: Codes 5 to 15 never set the pending bit.
- R8: While `pin_routed[n]` is 0, line n sets no pending bit, whatever its pin does.
- R9: The enable word at 0x210 has bit n for line n. `irq_out` is the OR over all lines of (pending AND enable), registered one cycle after the pending and enable state. A pending bit is set whether or not its line is enabled.
- R10: The pending word at 0x214 clears each bit written as 1 and ignores bits written as 0. Writing back the value just read clears all of them.
- R11: When an event and a clear hit the same pending bit in the same cycle, the bit stays set. Other bits cleared in that write still clear.
- R12: Reads of any other offset return zero, and writes to them change no register.
- R13: A pin change applied between clock edges is visible in the pending word after the third following rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Raw pin levels, one per line |
| pin_routed | input | 32 | From the pin mux: 1 when line n's pin is routed to the interrupt function |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; zero when no read is selected |
| irq_out | output | 1 | Combined interrupt request to the parent controller |

## Verification
An event that sets a pending bit and a software write that clears the same bit can land in the same cycle. The bench provokes this with a pin edge timed so that the detected event sits in exactly the cycle whose closing edge samples the clear write. A second, already-pending line is cleared in that same write. The first bit must read back set while the second reads back clear. Level modes give a held form of the same collision: a clear written during an active level must leave the bit set.

// File: rtl/pin_eint_pkg.sv
package pin_eint_pkg;

    localparam int LINES_PER_WORD = 8;
    localparam int MODE_W         = 4;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_mode_e;

    localparam logic [11:0] CFG_BASE = 12'h200;
    localparam logic [11:0] EN_OFS   = 12'h210;
    localparam logic [11:0] PEND_OFS = 12'h214;

endpackage

// File: rtl/pin_eint_sync.sv
module pin_eint_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;

    // the compared sample pair always advances by one stage per clock
    AST_SAMPLE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1 |=> (prev_o == $past(cur_o))); // R13

endmodule

// File: rtl/pin_eint_detect.sv
module pin_eint_detect
    import pin_eint_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cur_i,
    input  logic              prev_i,
    input  logic              routed_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              evt_o
);

    logic hit_w;

    always_comb begin
        case (mode_i)
            TRIG_RISE: hit_w = cur_i & ~prev_i;
            TRIG_FALL: hit_w = ~cur_i & prev_i;
            TRIG_HIGH: hit_w = cur_i;
            TRIG_LOW:  hit_w = ~cur_i;
            TRIG_BOTH: hit_w = cur_i ^ prev_i;
            default:   hit_w = 1'b0;
        endcase
        evt_o = hit_w & routed_i;
    end

    AST_RESERVED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i > 4'd4) |-> !evt_o); // R7

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_o && (mode_i == 4'd0 || mode_i == 4'd1 || mode_i == 4'd4)) |-> (cur_i != prev_i)); // R5

endmodule

// File: rtl/pin_eint_regs.sv
module pin_eint_regs
    import pin_eint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              sel_i,
    input  logic                              we_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    input  logic [NUM_LINES-1:0]              evt_i,
    output logic [DATA_W-1:0]                 rdata_o,
    output logic [NUM_LINES-1:0][MODE_W-1:0]  cfg_o,
    output logic [NUM_LINES-1:0]              pend_o,
    output logic                              irq_o
);

    localparam int LPW       = LINES_PER_WORD;
    localparam int CFG_WORDS = (NUM_LINES + LPW - 1) / LPW;

    typedef struct packed {
        logic [NUM_LINES-1:0][MODE_W-1:0] cfg;
        logic [NUM_LINES-1:0]             en;
        logic [NUM_LINES-1:0]             pend;
        logic                             irq;
    } regs_t;

    regs_t st_d, st_q;

    logic                 wr_w;
    logic [NUM_LINES-1:0] clr_w;

    function automatic logic [ADDR_W-1:0] cfg_addr(input int w);
        return ADDR_W'(CFG_BASE) + ADDR_W'(4 * w);
    endfunction

    always_comb begin
        st_d  = st_q;
        wr_w  = sel_i & we_i;
        clr_w = '0;
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (wr_w && addr_i == cfg_addr(w)) begin
                for (int j = 0; j < LPW; j++) begin
                    if (w * LPW + j < NUM_LINES)
                        st_d.cfg[w * LPW + j] = wdata_i[j * MODE_W +: MODE_W];
                end
            end
        end
        if (wr_w && addr_i == ADDR_W'(EN_OFS))
            st_d.en = wdata_i[NUM_LINES-1:0];
        if (wr_w && addr_i == ADDR_W'(PEND_OFS))
            clr_w = wdata_i[NUM_LINES-1:0];
        // a new event outranks a clear of the same bit
        st_d.pend = (st_q.pend & ~clr_w) | evt_i;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !we_i) begin
            for (int w = 0; w < CFG_WORDS; w++) begin
                if (addr_i == cfg_addr(w)) begin
                    for (int j = 0; j < LPW; j++) begin
                        if (w * LPW + j < NUM_LINES)
                            rdata_o[j * MODE_W +: MODE_W] = st_q.cfg[w * LPW + j];
                    end
                end
            end
            if (addr_i == ADDR_W'(EN_OFS))   rdata_o = DATA_W'(st_q.en);
            if (addr_i == ADDR_W'(PEND_OFS)) rdata_o = DATA_W'(st_q.pend);
        end
    end

    assign cfg_o  = st_q.cfg;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R11

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr_w & ~evt_i)) |=> ((pend_o & $past(clr_w & ~evt_i)) == '0)); // R10

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1 |=> (($past(pend_o) & ~pend_o & ~$past(clr_w)) == '0)); // R10

    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(pend_o & st_q.en)) |=> irq_o); // R9

    AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_o & st_q.en) == '0) |=> !irq_o); // R9

endmodule

// File: rtl/pin_eint_ctrl.sv
module pin_eint_ctrl
    import pin_eint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic [NUM_LINES-1:0] pin_routed,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_out
);

    logic [NUM_LINES-1:0]             cur_w;
    logic [NUM_LINES-1:0]             prev_w;
    logic [NUM_LINES-1:0]             evt_w;
    logic [NUM_LINES-1:0]             pend_w;
    logic [NUM_LINES-1:0][MODE_W-1:0] cfg_w;

    pin_eint_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .raw_i  (pin_in),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        pin_eint_detect u_det (
            .clk_i    (clk),
            .rst_ni   (rst_n),
            .cur_i    (cur_w[n]),
            .prev_i   (prev_w[n]),
            .routed_i (pin_routed[n]),
            .mode_i   (cfg_w[n]),
            .evt_o    (evt_w[n])
        );
    end

    pin_eint_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .sel_i   (bus_sel),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .evt_i   (evt_w),
        .rdata_o (bus_rdata),
        .cfg_o   (cfg_w),
        .pend_o  (pend_w),
        .irq_o   (irq_out)
    );

    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((pend_w & ~$past(pend_w) & ~$past(pin_routed)) == '0)); // R8

    AST_NO_READ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |-> (bus_rdata == '0)); // R12

endmodule

// File: tb/pin_eint_ctrl_test.sv
module pin_eint_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CFG0 = 12'h200;
    localparam logic [11:0] A_CFG1 = 12'h204;
    localparam logic [11:0] A_CFG2 = 12'h208;
    localparam logic [11:0] A_CFG3 = 12'h20C;
    localparam logic [11:0] A_EN   = 12'h210;
    localparam logic [11:0] A_PEND = 12'h214;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_routed = '1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    pin_eint_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .pin_routed (pin_routed),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_out    (irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pin_in[i] = v;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CFG0, d); check("R1 cfg0", d, 32'h0);
        rd(A_CFG1, d); check("R1 cfg1", d, 32'h0);
        rd(A_CFG2, d); check("R1 cfg2", d, 32'h0);
        rd(A_CFG3, d); check("R1 cfg3", d, 32'h0);
        rd(A_EN, d);   check("R1 enable", d, 32'h0);
        rd(A_PEND, d); check("R1 pending", d, 32'h0);
        check("R1 irq", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_layout;
        logic [31:0] d;
        wr(A_CFG1, 32'h8765_4321);
        wr(A_CFG3, 32'hA5C3_1E0F);
        rd(A_CFG1, d); check("R2 cfg1 readback", d, 32'h8765_4321);
        rd(A_CFG3, d); check("R2 cfg3 readback", d, 32'hA5C3_1E0F);
        rd(A_CFG0, d); check("R2 cfg0 untouched", d, 32'h0);
        wr(A_CFG1, 32'h0);
        wr(A_CFG3, 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, d); check("R2 pending cleared after restore", d, 32'h0);
    endtask

    task automatic t_undef;
        logic [31:0] d;
        wr(12'h218, 32'hFFFF_FFFF);
        wr(12'h1FC, 32'hFFFF_FFFF);
        wr(12'h610, 32'hFFFF_FFFF);
        rd(12'h218, d); check("R12 read 0x218", d, 32'h0);
        rd(12'h1FC, d); check("R12 read 0x1FC", d, 32'h0);
        rd(12'h610, d); check("R12 read 0x610", d, 32'h0);
        rd(A_EN, d);    check("R12 enable untouched", d, 32'h0);
        rd(A_CFG3, d);  check("R12 cfg3 untouched", d, 32'h0);
        check("R12 irq stays low", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_rise;
        logic [31:0] d;
        @(negedge clk);
        pin_in[13] = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_PEND;
        @(posedge clk); @(posedge clk); #1;
        check("R13 not pending after two edges", bus_rdata & 32'h2000, 32'h0);
        @(posedge clk); #1;
        check("R13 pending after third edge", bus_rdata & 32'h2000, 32'h2000);
        bus_sel = 1'b0;
        check("R9 pending but disabled gives no irq", {31'h0, irq_out}, 32'h0);
        wr(A_EN, 32'h2000);
        check("R9 irq registered after enable", {31'h0, irq_out}, 32'h0);
        wait_cyc(1);
        check("R9 irq asserted", {31'h0, irq_out}, 32'h1);
        wr(A_PEND, 32'h2000);
        wait_cyc(1);
        check("R9 irq drops one cycle after clear", {31'h0, irq_out}, 32'h0);
        wait_cyc(5);
        rd(A_PEND, d); check("R3 held high no repeat", d & 32'h2000, 32'h0);
        set_pin(13, 1'b0);
        wait_cyc(5);
        rd(A_PEND, d); check("R3 falling ignored", d & 32'h2000, 32'h0);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        set_pin(13, 1'b1);
        wait_cyc(4);
        wr(A_PEND, 32'h0);
        rd(A_PEND, d); check("R10 write zero no effect", d & 32'h2000, 32'h2000);
        wr(A_PEND, ~32'h2000);
        rd(A_PEND, d); check("R10 other bits leave bit", d & 32'h2000, 32'h2000);
        wr(A_PEND, d);
        rd(A_PEND, d); check("R10 write back read value", d, 32'h0);
        set_pin(13, 1'b0);
        wait_cyc(3);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        wr(A_CFG0, 32'h0000_0100);
        set_pin(2, 1'b1);
        wait_cyc(5);
        rd(A_PEND, d); check("R4 rising ignored", d & 32'h4, 32'h0);
        set_pin(2, 1'b0);
        wait_cyc(4);
        rd(A_PEND, d); check("R4 falling sets", d & 32'h4, 32'h4);
        wr(A_PEND, 32'h4);
    endtask

    task automatic t_both;
        logic [31:0] d;
        wr(A_CFG3, 32'h4000_0000);
        set_pin(31, 1'b1);
        wait_cyc(4);
        rd(A_PEND, d); check("R5 rise sets", d & 32'h8000_0000, 32'h8000_0000);
        wr(A_PEND, 32'h8000_0000);
        rd(A_PEND, d); check("R5 cleared", d & 32'h8000_0000, 32'h0);
        set_pin(31, 1'b0);
        wait_cyc(4);
        rd(A_PEND, d); check("R5 fall sets", d & 32'h8000_0000, 32'h8000_0000);
        wr(A_PEND, 32'h8000_0000);
    endtask

    task automatic t_level;
        logic [31:0] d;
        set_pin(21, 1'b1);
        wait_cyc(3);
        wr(A_CFG2, 32'h0032_0000);
        wait_cyc(2);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, d); check("R6 quiet before level", d & 32'h0030_0000, 32'h0);
        set_pin(20, 1'b1);
        wait_cyc(4);
        rd(A_PEND, d); check("R6 high level sets", d & 32'h0010_0000, 32'h0010_0000);
        wr(A_PEND, 32'h0010_0000);
        rd(A_PEND, d); check("R6 high clear overridden", d & 32'h0010_0000, 32'h0010_0000);
        set_pin(20, 1'b0);
        wait_cyc(4);
        wr(A_PEND, 32'h0010_0000);
        rd(A_PEND, d); check("R6 high clear after release", d & 32'h0010_0000, 32'h0);
        set_pin(21, 1'b0);
        wait_cyc(4);
        rd(A_PEND, d); check("R6 low level sets", d & 32'h0020_0000, 32'h0020_0000);
        wr(A_PEND, 32'h0020_0000);
        rd(A_PEND, d); check("R6 low clear overridden", d & 32'h0020_0000, 32'h0020_0000);
        set_pin(21, 1'b1);
        wait_cyc(4);
        wr(A_PEND, 32'h0020_0000);
        rd(A_PEND, d); check("R6 low clear after release", d & 32'h0020_0000, 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(A_CFG0, 32'hF500_0100);
        set_pin(6, 1'b1); set_pin(7, 1'b1);
        wait_cyc(4);
        set_pin(6, 1'b0); set_pin(7, 1'b0);
        wait_cyc(4);
        rd(A_PEND, d); check("R7 codes 5 and 15 silent", d & 32'hC0, 32'h0);
    endtask

    task automatic t_routed;
        logic [31:0] d;
        @(negedge clk); pin_routed[9] = 1'b0;
        set_pin(9, 1'b1);
        wait_cyc(5);
        rd(A_PEND, d); check("R8 unrouted edge ignored", d & 32'h200, 32'h0);
        set_pin(9, 1'b0);
        wait_cyc(4);
        @(negedge clk); pin_routed[9] = 1'b1;
        wait_cyc(2);
        set_pin(9, 1'b1);
        wait_cyc(4);
        rd(A_PEND, d); check("R8 routed edge sets", d & 32'h200, 32'h200);
        wr(A_PEND, 32'h200);
    endtask

    task automatic t_irq_or;
        logic [31:0] d;
        wr(A_EN, 32'h18);
        set_pin(5, 1'b1);
        wait_cyc(4);
        rd(A_PEND, d); check("R9 disabled line pends", d & 32'h20, 32'h20);
        wait_cyc(2);
        check("R9 disabled line no irq", {31'h0, irq_out}, 32'h0);
        set_pin(3, 1'b1); set_pin(4, 1'b1);
        wait_cyc(5);
        check("R9 two enabled lines irq", {31'h0, irq_out}, 32'h1);
        wr(A_PEND, 32'h8);
        wait_cyc(1);
        check("R9 one line left irq holds", {31'h0, irq_out}, 32'h1);
        wr(A_PEND, 32'h10);
        wait_cyc(1);
        check("R9 last line cleared irq drops", {31'h0, irq_out}, 32'h0);
        wr(A_EN, 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
    endtask

    task automatic t_setwins;
        logic [31:0] d;
        set_pin(14, 1'b1);
        wait_cyc(4);
        @(negedge clk);
        pin_in[13] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h6000;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(A_PEND, d); check("R11 set beats clear, other bit clears", d & 32'h6000, 32'h2000);
        wr(A_PEND, 32'h2000);
        rd(A_PEND, d); check("R11 later clear takes", d & 32'h6000, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_layout();
        t_undef();
        t_rise();
        t_w1c();
        t_fall();
        t_both();
        t_level();
        t_reserved();
        t_routed();
        t_irq_or();
        t_setwins();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

endmodule